// File: doc/BRIEF.md
# Descriptor-Chained Audio DMA Channel

This block is a single DMA channel that works through a chain of transfer descriptors kept in a small local descriptor RAM. Software loads the descriptors, then programs a first descriptor index, a number of descriptors to run and a priority level. A control word holds four bits: run, reset, interrupt-on-complete and circular. Once started, the channel fetches each descriptor and copies its byte count from the source address to the destination address. Each 32-bit word is copied as one read request and then one write request on a simple request/grant memory port.

The channel drives the index of the descriptor in progress and a busy status bit. It also raises a completion flag that software clears by writing a one. In circular mode the chain loops back to its first descriptor, which suits a ping-pong audio buffer. A running channel is halted with a stop handshake: clear run, then hold the reset bit while busy is still set.

Top module: `audio_desc_dma`

## Requirements
- R1: After reset, busy, irq and memReq are low and curDesc is 0.
- R2: Descriptor i starts at byte address i*12 of the descriptor RAM and holds three words: the source address at +0, the destination address at +4 and a transfer word at +8. In the transfer word, bits 15:0 are the byte count (a multiple of 4), bits 21:16 are the transfer attribute and bit 22 is a flag. Every memory request made for that descriptor carries the attribute on memAttr and the flag on memFlag.
- R3: cfgSel selects the target of a configuration write: 0 is the start index, 1 the descriptor count, 2 the priority and 3 the control word. Control word bits: bit 0 run, bit 1 reset, bit 2 interrupt-on-complete, bit 3 circular. If run goes from 0 to 1 (with reset 0) while the channel is idle, busy is high on the cycle after the write and processing begins at the start index. A count of 0 starts nothing.
- R4: Each word is copied as a read at the source address and then a write of the read data at the destination address; both addresses advance by 4 per word. An ungranted request stays asserted and does not change.
- R5: A descriptor whose byte count is 0 is retired without any memory request.
- R6: With circular off, busy drops after the last descriptor of the chain. curDesc then shows the index of that last descriptor.
- R7: With circular on and run set, the channel goes back to the start index after the last descriptor. If run has been cleared, it stops at the end of the chain.
- R8: Writes to the start index, count and priority are ignored while run is set. prioLevel shows the stored priority.
- R9: While the reset bit is set, busy is low from the second cycle after the write that set it, and no further memory requests are made.
- R10: Retiring a descriptor sets the completion flag only if interrupt-on-complete is set.
- R11: A clear write with bit CH_NUM+16 set clears the completion flag; other bits of the clear word have no effect.
- R12: irq is the completion flag ANDed with globalIrqEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| descWe | input | 1 | Descriptor RAM write strobe |
| descAddr | input | 8 | Descriptor RAM byte address (word aligned) |
| descWdata | input | 32 | Descriptor RAM write data |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration target (see R3) |
| cfgData | input | 32 | Configuration write data |
| intClrWe | input | 1 | Interrupt status clear strobe |
| intClrData | input | 32 | Write-one-to-clear word |
| globalIrqEn | input | 1 | Global interrupt enable |
| memGnt | input | 1 | Memory request accepted this cycle |
| memRdata | input | 32 | Read data, valid with memGnt on a read |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Request byte address |
| memWdata | output | 32 | Write data |
| memAttr | output | 6 | Transfer attribute of the current descriptor |
| memFlag | output | 1 | Bit-22 flag of the current descriptor |
| curDesc | output | 4 | Index of the descriptor in progress |
| busy | output | 1 | Channel busy status |
| irq | output | 1 | Completion interrupt |
| prioLevel | output | 3 | Stored priority level |

## Verification
The assertions assume every descriptor byte count is a multiple of 4. They also assume the memory returns read data in the same cycle it grants a read. The stimulus loads only such counts, and its memory model answers reads combinationally from the request address. The stimulus reprograms the start index and priority while the channel runs, to confirm those writes are dropped. Grants are sometimes withheld on alternate cycles, so requests must stay held.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_WRITE,
    ST_RETIRE
  } chanState_t;

  typedef struct packed {
    logic loadDesc;
    logic latchRd;
    logic stepWord;
    logic selDst;
  } dpStrobes_t;

  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_PRIO  = 2'd2;
  localparam logic [1:0] SEL_CTRL  = 2'd3;
endpackage

// File: rtl/dma_chan_datapath.sv
module dma_chan_datapath
  import dma_chan_pkg::*;
#(
  parameter int DESC_DEPTH = 16,
  parameter int ATTR_W     = 6,
  localparam int IDX_W     = $clog2(DESC_DEPTH),
  localparam int WORDS     = DESC_DEPTH * 3,
  localparam int WA_W      = $clog2(WORDS),
  localparam int DESC_AW   = WA_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               descWe,
  input  logic [DESC_AW-1:0] descAddr,
  input  logic [31:0]        descWdata,
  input  logic [IDX_W-1:0]   fetchIdx,
  input  dpStrobes_t         strb,
  input  logic [31:0]        memRdata,
  output logic               descZero,
  output logic               lastWord,
  output logic [31:0]        memAddr,
  output logic [31:0]        memWdata,
  output logic [ATTR_W-1:0]  memAttr,
  output logic               memFlag
);
  logic [31:0] descRam [WORDS];
  logic [WA_W-1:0] wrIdx, baseIdx;
  logic [31:0] srcWord, dstWord, xferWord;
  logic [31:0] srcAddr, dstAddr, dataReg;
  logic [15:0] bytesLeft;
  logic [ATTR_W-1:0] attrReg;
  logic flagReg;

  assign wrIdx = descAddr[DESC_AW-1:2];

  always_ff @(posedge clk) begin
    if (descWe && (int'(wrIdx) < WORDS)) descRam[wrIdx] <= descWdata;
  end

  assign baseIdx  = WA_W'(fetchIdx) + WA_W'(fetchIdx) + WA_W'(fetchIdx);
  assign srcWord  = descRam[baseIdx];
  assign dstWord  = descRam[baseIdx + WA_W'(1)];
  assign xferWord = descRam[baseIdx + WA_W'(2)];
  assign descZero = (xferWord[15:0] == 16'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr   <= '0;
      dstAddr   <= '0;
      bytesLeft <= '0;
      dataReg   <= '0;
      attrReg   <= '0;
      flagReg   <= 1'b0;
    end else begin
      if (strb.loadDesc) begin
        srcAddr   <= srcWord;
        dstAddr   <= dstWord;
        bytesLeft <= xferWord[15:0];
        attrReg   <= xferWord[16 +: ATTR_W];
        flagReg   <= xferWord[22];
      end
      if (strb.latchRd) dataReg <= memRdata;
      if (strb.stepWord) begin
        srcAddr   <= srcAddr + 32'd4;
        dstAddr   <= dstAddr + 32'd4;
        bytesLeft <= bytesLeft - 16'd4;
      end
    end
  end

  assign lastWord = (bytesLeft == 16'd4);
  assign memAddr  = strb.selDst ? dstAddr : srcAddr;
  assign memWdata = dataReg;
  assign memAttr  = attrReg;
  assign memFlag  = flagReg;

  // R2: byte counts are word multiples (input assumption)
  assert_count_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDesc |-> xferWord[1:0] == 2'b00);
  // R4: a word step never happens with nothing left
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepWord |-> bytesLeft != 16'd0);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int DESC_DEPTH = 16,
  parameter int PRIO_W     = 3,
  parameter int CH_NUM     = 0,
  localparam int IDX_W     = $clog2(DESC_DEPTH),
  localparam int CNT_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [31:0]       cfgData,
  input  logic              intClrWe,
  input  logic [31:0]       intClrData,
  input  logic              globalIrqEn,
  input  logic              memGnt,
  input  logic              descZero,
  input  logic              lastWord,
  output dpStrobes_t        strb,
  output logic [IDX_W-1:0]  curIdx,
  output logic              busy,
  output logic              irq,
  output logic [PRIO_W-1:0] prioLevel,
  output logic              memReq,
  output logic              memWe
);
  chanState_t state;
  logic [IDX_W-1:0]  startIdx;
  logic [CNT_W-1:0]  descCnt, leftCnt;
  logic runB, rstB, iocB, circB, compFlag;
  logic ctrlWr, startGo, setFlag, clrHit;

  assign ctrlWr  = cfgWe && (cfgSel == SEL_CTRL);
  assign startGo = ctrlWr && cfgData[0] && !cfgData[1] && !runB && (state == ST_IDLE);
  assign setFlag = (state == ST_RETIRE) && iocB;
  assign clrHit  = intClrWe && intClrData[CH_NUM + 16];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startIdx  <= '0;
      descCnt   <= '0;
      prioLevel <= '0;
      runB      <= 1'b0;
      rstB      <= 1'b0;
      iocB      <= 1'b0;
      circB     <= 1'b0;
    end else if (cfgWe) begin
      unique case (cfgSel)
        SEL_START: if (!runB) startIdx  <= cfgData[IDX_W-1:0];
        SEL_COUNT: if (!runB) descCnt   <= cfgData[CNT_W-1:0];
        SEL_PRIO:  if (!runB) prioLevel <= cfgData[PRIO_W-1:0];
        default: begin
          runB  <= cfgData[0];
          rstB  <= cfgData[1];
          iocB  <= cfgData[2];
          circB <= cfgData[3];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curIdx  <= '0;
      leftCnt <= '0;
    end else if (rstB) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (startGo && (descCnt != '0)) begin
          state   <= ST_FETCH;
          curIdx  <= startIdx;
          leftCnt <= descCnt;
        end
        ST_FETCH: state <= descZero ? ST_RETIRE : ST_READ;
        ST_READ:  if (memGnt) state <= ST_WRITE;
        ST_WRITE: if (memGnt) state <= lastWord ? ST_RETIRE : ST_READ;
        default: begin
          if (leftCnt == CNT_W'(1)) begin
            if (circB && runB) begin
              state   <= ST_FETCH;
              curIdx  <= startIdx;
              leftCnt <= descCnt;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            state   <= ST_FETCH;
            curIdx  <= curIdx + IDX_W'(1);
            leftCnt <= leftCnt - CNT_W'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) compFlag <= 1'b0;
    else       compFlag <= setFlag || (compFlag && !clrHit);
  end

  assign busy   = (state != ST_IDLE);
  assign memReq = (state == ST_READ) || (state == ST_WRITE);
  assign memWe  = (state == ST_WRITE);
  assign irq    = compFlag && globalIrqEn;

  assign strb.loadDesc = (state == ST_FETCH);
  assign strb.latchRd  = (state == ST_READ) && memGnt;
  assign strb.stepWord = (state == ST_WRITE) && memGnt;
  assign strb.selDst   = (state == ST_WRITE);

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (runB && cfgWe && cfgSel == SEL_START) |=> $stable(startIdx));
  assert_reset_stops_R9: assert property (@(posedge clk) disable iff (!rstN)
    rstB |=> !busy && !memReq);
  assert_flag_needs_ioc_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(compFlag) |-> $past(iocB));
  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (clrHit && !setFlag) |=> !compFlag);
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt && !rstB) |=> memReq && $stable(memWe));
endmodule

// File: rtl/audio_desc_dma.sv
module audio_desc_dma
  import dma_chan_pkg::*;
#(
  parameter int DESC_DEPTH = 16,
  parameter int ATTR_W     = 6,
  parameter int PRIO_W     = 3,
  parameter int CH_NUM     = 0,
  localparam int IDX_W     = $clog2(DESC_DEPTH),
  localparam int DESC_AW   = $clog2(DESC_DEPTH * 3) + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               descWe,
  input  logic [DESC_AW-1:0] descAddr,
  input  logic [31:0]        descWdata,
  input  logic               cfgWe,
  input  logic [1:0]         cfgSel,
  input  logic [31:0]        cfgData,
  input  logic               intClrWe,
  input  logic [31:0]        intClrData,
  input  logic               globalIrqEn,
  input  logic               memGnt,
  input  logic [31:0]        memRdata,
  output logic               memReq,
  output logic               memWe,
  output logic [31:0]        memAddr,
  output logic [31:0]        memWdata,
  output logic [ATTR_W-1:0]  memAttr,
  output logic               memFlag,
  output logic [IDX_W-1:0]   curDesc,
  output logic               busy,
  output logic               irq,
  output logic [PRIO_W-1:0]  prioLevel
);
  dpStrobes_t strb;
  logic descZero, lastWord;

  dma_chan_ctrl #(.DESC_DEPTH(DESC_DEPTH), .PRIO_W(PRIO_W), .CH_NUM(CH_NUM)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .intClrWe(intClrWe), .intClrData(intClrData), .globalIrqEn(globalIrqEn),
    .memGnt(memGnt), .descZero(descZero), .lastWord(lastWord), .strb(strb),
    .curIdx(curDesc), .busy(busy), .irq(irq), .prioLevel(prioLevel),
    .memReq(memReq), .memWe(memWe)
  );

  dma_chan_datapath #(.DESC_DEPTH(DESC_DEPTH), .ATTR_W(ATTR_W)) uDp (
    .clk(clk), .rstN(rstN), .descWe(descWe), .descAddr(descAddr),
    .descWdata(descWdata), .fetchIdx(curDesc), .strb(strb), .memRdata(memRdata),
    .descZero(descZero), .lastWord(lastWord), .memAddr(memAddr),
    .memWdata(memWdata), .memAttr(memAttr), .memFlag(memFlag)
  );
endmodule

// File: tb/tb_audio_desc_dma.sv
module tb_audio_desc_dma;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic descWe = 1'b0;
  logic [7:0] descAddr = '0;
  logic [31:0] descWdata = '0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [31:0] cfgData = '0;
  logic intClrWe = 1'b0;
  logic [31:0] intClrData = '0;
  logic globalIrqEn = 1'b0;
  logic memGnt;
  logic [31:0] memRdata;
  logic memReq, memWe, memFlag, busy, irq;
  logic [31:0] memAddr, memWdata;
  logic [5:0] memAttr;
  logic [3:0] curDesc;
  logic [2:0] prioLevel;

  logic [31:0] mem [256];
  logic gntAlways = 1'b1;
  logic stallTick = 1'b0;
  int wrCount = 0;
  int attrErr = 0;
  logic [5:0] expAttr = '0;
  logic expFlag = 1'b0;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  audio_desc_dma dut (
    .clk(clk), .rstN(rstN), .descWe(descWe), .descAddr(descAddr),
    .descWdata(descWdata), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .intClrWe(intClrWe), .intClrData(intClrData), .globalIrqEn(globalIrqEn),
    .memGnt(memGnt), .memRdata(memRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAttr(memAttr), .memFlag(memFlag),
    .curDesc(curDesc), .busy(busy), .irq(irq), .prioLevel(prioLevel)
  );

  assign memGnt   = memReq && (gntAlways || stallTick);
  assign memRdata = mem[memAddr[9:2]];

  always @(posedge clk) begin
    stallTick <= ~stallTick;
    if (memReq && memGnt && memWe) begin
      mem[memAddr[9:2]] <= memWdata;
      wrCount <= wrCount + 1;
    end
    if (memReq && (memAttr != expAttr || memFlag != expFlag)) attrErr <= attrErr + 1;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic clrWrite(input logic [31:0] data);
    @(negedge clk);
    intClrWe = 1'b1; intClrData = data;
    @(negedge clk);
    intClrWe = 1'b0;
  endtask

  task automatic descWr(input int idx, input logic [31:0] src, input logic [31:0] dst, input logic [31:0] xfer);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      descWe = 1'b1;
      descAddr = 8'(idx * 12 + k * 4);
      descWdata = (k == 0) ? src : (k == 1) ? dst : xfer;
    end
    @(negedge clk);
    descWe = 1'b0;
  endtask

  task automatic waitIdle(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(busy == 0 && irq == 0 && memReq == 0, "R1 idle outputs", {busy, irq, memReq}, 0);
    check(curDesc == 0, "R1 curDesc", 32'(curDesc), 0);
  endtask

  task automatic testChain();
    gntAlways = 1'b0;
    expAttr = 6'd5; expFlag = 1'b1;
    globalIrqEn = 1'b1;
    descWr(0, 32'h000, 32'h100, (32'd1 << 22) | (32'd5 << 16) | 32'd16);
    descWr(1, 32'h040, 32'h200, (32'd1 << 22) | (32'd5 << 16) | 32'd8);
    cfg(2'd0, 0); cfg(2'd1, 2); cfg(2'd2, 3);
    cfg(2'd3, 32'h5);
    check(busy == 1, "R3 busy after run", 32'(busy), 1);
    waitIdle(500);
    check(busy == 0, "R6 chain ends", 32'(busy), 0);
    for (int i = 0; i < 4; i++)
      check(mem[64 + i] == 32'hA000_0000 + i, "R4 first block", mem[64 + i], 32'hA000_0000 + i);
    check(mem[128] == 32'hA000_0010 && mem[129] == 32'hA000_0011, "R4 second block", mem[129], 32'hA000_0011);
    check(wrCount == 6, "R4 write count", wrCount, 6);
    check(curDesc == 1, "R6 last index", 32'(curDesc), 1);
    check(attrErr == 0, "R2 attr and flag", attrErr, 0);
    check(irq == 1, "R10 flag set", 32'(irq), 1);
    check(prioLevel == 3, "R8 prio stored", 32'(prioLevel), 3);
    gntAlways = 1'b1;
  endtask

  task automatic testClear();
    clrWrite(32'h0002_0000);
    check(irq == 1, "R11 other bit ignored", 32'(irq), 1);
    clrWrite(32'h0001_0000);
    check(irq == 0, "R11 flag cleared", 32'(irq), 0);
    cfg(2'd3, 0);
  endtask

  task automatic testZero();
    int w0;
    expAttr = 6'd2; expFlag = 1'b0;
    descWr(2, 32'h080, 32'h300, (32'd2 << 16));
    descWr(3, 32'h084, 32'h304, (32'd2 << 16) | 32'd4);
    w0 = wrCount;
    cfg(2'd0, 2); cfg(2'd1, 2);
    cfg(2'd3, 32'h1);
    waitIdle(200);
    check(wrCount - w0 == 1, "R5 zero desc no data", wrCount - w0, 1);
    check(mem[192] == 0, "R5 zero desc dest untouched", mem[192], 0);
    check(mem[193] == 32'hA000_0021, "R5 next desc copied", mem[193], 32'hA000_0021);
    check(curDesc == 3, "R6 last index zero run", 32'(curDesc), 3);
    check(irq == 0, "R10 no flag without ioc", 32'(irq), 0);
    cfg(2'd3, 0);
    cfg(2'd1, 0);
    cfg(2'd3, 32'h1);
    check(busy == 0, "R3 zero count starts nothing", 32'(busy), 0);
    cfg(2'd3, 0);
  endtask

  task automatic testCircular();
    logic [3:0] prev;
    bit wrapSeen, bad;
    int w0;
    expAttr = 6'd1; expFlag = 1'b0;
    descWr(4, 32'h000, 32'h100, (32'd1 << 16) | 32'd8);
    descWr(5, 32'h010, 32'h110, (32'd1 << 16) | 32'd8);
    cfg(2'd0, 4); cfg(2'd1, 2);
    cfg(2'd3, 32'hD);
    cfg(2'd0, 8);
    cfg(2'd2, 7);
    check(prioLevel == 3, "R8 prio write ignored", 32'(prioLevel), 3);
    wrapSeen = 0; bad = 0; prev = curDesc;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (prev == 5 && curDesc == 4) wrapSeen = 1;
      if (curDesc != 4 && curDesc != 5) bad = 1;
      prev = curDesc;
    end
    check(wrapSeen && busy, "R7 wraps to start", {wrapSeen, busy}, 2'b11);
    check(!bad, "R8 start write ignored", 32'(curDesc), 4);
    cfg(2'd3, 32'hA);
    @(negedge clk);
    check(busy == 0, "R9 reset stops channel", 32'(busy), 0);
    w0 = wrCount;
    repeat (5) @(negedge clk);
    check(wrCount == w0 && memReq == 0, "R9 no requests in reset", wrCount - w0, 0);
    cfg(2'd3, 0);
    cfg(2'd3, 32'hD);
    repeat (10) @(negedge clk);
    cfg(2'd3, 32'hC);
    waitIdle(200);
    check(busy == 0, "R7 stops when run cleared", 32'(busy), 0);
  endtask

  task automatic testGate();
    globalIrqEn = 1'b0;
    @(negedge clk);
    check(irq == 0, "R12 gated off", 32'(irq), 0);
    globalIrqEn = 1'b1;
    @(negedge clk);
    check(irq == 1, "R12 gated on", 32'(irq), 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i < 64) ? 32'hA000_0000 + 32'(i) : 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testChain();
    testClear();
    testZero();
    testCircular();
    testGate();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule